// File: doc/BRIEF.md
# Arithmetic Unit with Compare Flag Register

This block is the arithmetic stage of a small accumulator datapath. It takes an accumulator operand and a second operand, both 16 bits wide, together with a 2-bit operation code. It computes a sum or a difference, and it also produces five status flags: negative, carry/borrow, greater, equal and less. The greater, equal and less flags come from a dedicated unsigned magnitude comparator. A compare operation evaluates the same subtraction as subtract, but it returns no result value. It only changes the flags.

The flags are held in a register that loads on a clock edge where the write enable is high and the operation is not the idle code. A branch unit tests a single flag through a select-indexed read port. That port reads the registered flags. A branch that samples it in the same cycle as a flag write therefore sees the flags as they were before that edge.

Top module: `cmpalu_top`

## Requirements
- R1: While reset is asserted (active low) and after it is released, all five flags read zero until the first accepted flag write.
- R2: The operation code decodes as 2'b10 add (result = x + y mod 2^16) and 2'b11 subtract (result = x - y mod 2^16). For 2'b00 idle and 2'b01 compare, the result output is zero.
- R3: The flag vector has a fixed layout: bit 4 negative, bit 3 carry/borrow, bit 2 greater, bit 1 equal, bit 0 less.
- R4: On an accepted write, the negative flag takes bit 15 of the sum for add, and bit 15 of x - y for subtract and compare.
- R5: On an accepted add, the carry flag is the carry out of the unsigned 16-bit addition.
- R6: On an accepted subtract or compare, the carry flag is set exactly when x < y as unsigned numbers, which is when a borrow occurs.
- R7: On any accepted write, greater, equal and less take x > y, x == y and x < y as unsigned values, so exactly one of the three is set.
- R8: The flags change only on a rising edge where flag_we is high and the code is not idle. With flag_we low, or with the idle code, all five flags keep their value.
- R9: flag_bit returns the registered flag selected by flag_sel for values 0 to 4, using the R3 layout, and returns 0 for 5 to 7. It is combinational from the register, so a read made in a write cycle returns the value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| x_in | input | 16 | Accumulator operand |
| y_in | input | 16 | Second operand |
| op_in | input | 2 | Operation code (00 idle, 01 compare, 10 add, 11 subtract) |
| flag_we | input | 1 | Flag register write enable |
| flag_sel | input | 3 | Index of the flag presented on flag_bit |
| result | output | 16 | Arithmetic result (zero for idle and compare) |
| flags | output | 5 | Registered flags {N, C, G, E, L} |
| flag_bit | output | 1 | Selected single flag for the branch unit |

## Verification
A flag write and a branch-side flag read can fall in the same cycle. The bench provokes this by driving a compare with the write enable high while flag_sel points at the equal flag whose value is about to change. Before the edge, flag_bit must still show the old value. After the edge, it must show the new one. A second overlap occurs when the combinational result of an add is observed in the same cycle that its flags are loaded. The bench checks the sum before the edge and the flags after it, and each value is judged against a model computed with wide integer arithmetic.

// File: rtl/cmpalu_pkg.sv
package cmpalu_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_CMP  = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } alu_op_e;

  localparam int FLAG_COUNT = 5;
  localparam int FSEL_W     = $clog2(FLAG_COUNT);
  // flag bit positions, decoded by the branch unit
  localparam int FI_NEG   = 4;
  localparam int FI_CARRY = 3;
  localparam int FI_GT    = 2;
  localparam int FI_EQ    = 1;
  localparam int FI_LT    = 0;
endpackage

// File: rtl/cmpalu_compare.sv
module cmpalu_compare #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         eq,
  output logic         lt
);
  // unsigned magnitude comparison
  always_comb begin
    eq = (a == b);
    gt = (a > b);
    lt = !(a > b) && !(a == b);
  end
endmodule

// File: rtl/cmpalu_arith.sv
module cmpalu_arith
  import cmpalu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   op,
  output logic [W-1:0] result,
  output logic         arith_msb,
  output logic         arith_carry
);
  localparam int EXT_W = W + 1;

  function automatic logic [EXT_W-1:0] add_ext(input logic [W-1:0] p, input logic [W-1:0] q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  // top bit of the extended difference is the borrow
  function automatic logic [EXT_W-1:0] sub_ext(input logic [W-1:0] p, input logic [W-1:0] q);
    return {1'b0, p} - {1'b0, q};
  endfunction

  logic [EXT_W-1:0] sum_w;
  logic [EXT_W-1:0] dif_w;
  logic             pick_sum;
  logic [W-1:0]     chosen;

  always_comb begin
    sum_w       = add_ext(a, b);
    dif_w       = sub_ext(a, b);
    pick_sum    = (op == OP_ADD);
    chosen      = pick_sum ? sum_w[W-1:0] : dif_w[W-1:0];
    arith_msb   = chosen[W-1];
    arith_carry = pick_sum ? sum_w[W] : dif_w[W];
    unique case (op)
      OP_ADD, OP_SUB: result = chosen;
      default:        result = '0;
    endcase
  end
endmodule

// File: rtl/cmpalu_flagreg.sv
module cmpalu_flagreg #(
  parameter int NF = 5,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NF-1:0] d,
  input  logic [SW-1:0] sel,
  output logic [NF-1:0] q,
  output logic          bit_out
);
  localparam int SLOTS = 2 ** SW;

  logic [SLOTS-1:0] padded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NF) begin : g_live
      assign padded[i] = q[i];
    end else begin : g_zero
      assign padded[i] = 1'b0;
    end
  end

  assign bit_out = padded[sel];
endmodule

// File: rtl/cmpalu_top.sv
module cmpalu_top
  import cmpalu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIDTH-1:0]      x_in,
  input  logic [WIDTH-1:0]      y_in,
  input  logic [1:0]            op_in,
  input  logic                  flag_we,
  input  logic [FSEL_W-1:0]     flag_sel,
  output logic [WIDTH-1:0]      result,
  output logic [FLAG_COUNT-1:0] flags,
  output logic                  flag_bit
);
  logic                  arith_msb;
  logic                  arith_carry;
  logic                  cmp_gt, cmp_eq, cmp_lt;
  logic                  upd_en;
  logic [FLAG_COUNT-1:0] next_flags;

  cmpalu_arith #(.W(WIDTH)) u_arith (
    .a(x_in), .b(y_in), .op(op_in),
    .result(result), .arith_msb(arith_msb), .arith_carry(arith_carry)
  );

  cmpalu_compare #(.W(WIDTH)) u_cmp (
    .a(x_in), .b(y_in), .gt(cmp_gt), .eq(cmp_eq), .lt(cmp_lt)
  );

  assign upd_en = flag_we && (op_in != OP_IDLE);

  always_comb begin
    next_flags           = '0;
    next_flags[FI_NEG]   = arith_msb;
    next_flags[FI_CARRY] = arith_carry;
    next_flags[FI_GT]    = cmp_gt;
    next_flags[FI_EQ]    = cmp_eq;
    next_flags[FI_LT]    = cmp_lt;
  end

  cmpalu_flagreg #(.NF(FLAG_COUNT), .SW(FSEL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .load(upd_en), .d(next_flags),
    .sel(flag_sel), .q(flags), .bit_out(flag_bit)
  );
endmodule

// File: rtl/cmpalu_checker.sv
module cmpalu_checker
  import cmpalu_pkg::*;
#(
  parameter int W = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [W-1:0]          x_in,
  input logic [1:0]            op_in,
  input logic                  flag_we,
  input logic [FSEL_W-1:0]     flag_sel,
  input logic [W-1:0]          result,
  input logic [FLAG_COUNT-1:0] flags,
  input logic                  flag_bit,
  input logic                  upd_en
);
  logic wr_add, wr_any, wr_sublike;
  assign wr_add     = flag_we && (op_in == OP_ADD);
  assign wr_any     = flag_we && (op_in != OP_IDLE);
  assign wr_sublike = flag_we && (op_in == OP_SUB || op_in == OP_CMP);

  p_quiet_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_in == OP_IDLE || op_in == OP_CMP) |-> (result == '0));

  p_neg_add_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add |=> (flags[FI_NEG] == $past(result[W-1])));

  p_carry_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_add |=> (flags[FI_CARRY] == ($past(result) < $past(x_in))));

  p_borrow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sublike |=> (flags[FI_CARRY] == flags[FI_LT]));

  p_gel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> ($countones(flags[FI_GT:FI_LT]) == 1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags));

  p_read_unused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_sel >= FSEL_W'(FLAG_COUNT)) |-> !flag_bit);
endmodule

bind cmpalu_top cmpalu_checker #(.W(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .x_in(x_in), .op_in(op_in), .flag_we(flag_we),
  .flag_sel(flag_sel), .result(result), .flags(flags), .flag_bit(flag_bit),
  .upd_en(upd_en)
);

// File: tb/cmpalu_top_test.sv
module cmpalu_top_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic [1:0]  op_in = 2'b00;
  logic        flag_we = 1'b0;
  logic [2:0]  flag_sel = '0;
  logic [15:0] result;
  logic [4:0]  flags;
  logic        flag_bit;

  int total = 0;
  int bad = 0;
  logic [4:0] shadow = '0;

  cmpalu_top uut (
    .clk(clk), .rst_n(rst_n), .x_in(x_in), .y_in(y_in), .op_in(op_in),
    .flag_we(flag_we), .flag_sel(flag_sel), .result(result), .flags(flags),
    .flag_bit(flag_bit)
  );

  always #(PERIOD/2) clk = ~clk;

  initial begin
    #(PERIOD * 5000);
    bad++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // model: flag layout {N,C,G,E,L}, computed with 32-bit integers
  function automatic logic [4:0] model(input int x, input int y, input logic [1:0] op,
                                       input logic we, input logic [4:0] old);
    int r;
    logic n, c;
    if (!we || op == 2'b00) return old;
    if (op == 2'b10) begin r = x + y; c = (r > 65535); end
    else begin r = x - y; c = (x < y); end
    n = ((r & 32'hFFFF) >= 32'h8000);
    return {n, c, x > y, x == y, x < y};
  endfunction

  function automatic logic [15:0] exp_result(input int x, input int y, input logic [1:0] op);
    if (op == 2'b10) return 16'((x + y) % 65536);
    if (op == 2'b11) return 16'((x - y + 65536) % 65536);
    return 16'h0;
  endfunction

  // drive at falling edge, check result before the edge, flags after it
  task automatic step(input string req, input int x, input int y,
                      input logic [1:0] op, input logic we);
    @(negedge clk);
    x_in = 16'(x); y_in = 16'(y); op_in = op; flag_we = we;
    #1;
    check({req, " R2 result"}, 32'(result), 32'(exp_result(x, y, op)));
    shadow = model(x, y, op, we, shadow);
    @(posedge clk); #1;
    check({req, " flags"}, 32'(flags), 32'(shadow));
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 reset flags", 32'(flags), 32'h0);
    for (int s = 0; s < 8; s++) begin
      flag_sel = 3'(s); #1;
      check("R1 reset read", 32'(flag_bit), 32'h0);
    end
  endtask

  task automatic t_add;
    step("R5 add no carry", 16'h1234, 16'h0101, 2'b10, 1'b1);
    step("R5 add carry wrap", 16'hFFFF, 16'h0001, 2'b10, 1'b1);
    step("R4 add negative", 16'h7FFF, 16'h0001, 2'b10, 1'b1);
    step("R7 add equal ops", 16'h8000, 16'h8000, 2'b10, 1'b1);
  endtask

  task automatic t_sub;
    step("R6 sub borrow", 5, 7, 2'b11, 1'b1);
    check("R3 neg at bit4", 32'(flags[4]), 32'h1);
    check("R3 lt at bit0", 32'(flags[0]), 32'h1);
    step("R6 sub no borrow", 7, 5, 2'b11, 1'b1);
    step("R4 sub big", 16'hF000, 16'h0001, 2'b11, 1'b1);
  endtask

  task automatic t_cmp;
    step("R7 cmp equal", 16'h00AA, 16'h00AA, 2'b01, 1'b1);
    step("R7 cmp greater unsigned", 16'h8000, 16'h0001, 2'b01, 1'b1);
    step("R6 cmp less", 16'h0001, 16'hFFFF, 2'b01, 1'b1);
  endtask

  task automatic t_hold;
    step("R8 we low", 16'hFFFF, 16'hFFFF, 2'b10, 1'b0);
    step("R8 idle with we", 3, 9, 2'b00, 1'b1);
    step("R8 sub we low", 0, 1, 2'b11, 1'b0);
  endtask

  task automatic t_read;
    step("R9 setup", 16'h0002, 16'h0009, 2'b11, 1'b1);
    for (int s = 0; s < 8; s++) begin
      flag_sel = 3'(s); #1;
      check("R9 read index", 32'(flag_bit), 32'((s < 5) ? shadow[s] : 1'b0));
    end
    // same-cycle write and read of the equal flag
    @(negedge clk);
    flag_sel = 3'd1; x_in = 16'd4; y_in = 16'd4; op_in = 2'b01; flag_we = 1'b1;
    #1;
    check("R9 read before edge", 32'(flag_bit), 32'h0);
    @(posedge clk); #1;
    check("R9 read after edge", 32'(flag_bit), 32'h1);
    shadow = model(4, 4, 2'b01, 1'b1, shadow);
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after release", 32'(flags), 32'h0);
    t_add;
    t_sub;
    t_cmp;
    t_hold;
    t_read;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule